// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a calendar clock that shares one bytewide bus with a general-purpose RAM. The top eight byte addresses of an 8k address window hold a control byte and seven time fields. Every address below that window reaches a RAM array. Time is held in packed BCD: century, year, month, date, day of week, hours (24-hour), minutes and seconds. The month length follows the calendar, and every year divisible by four is a leap year, which keeps the calendar correct through 2099. A one-pulse-per-second strobe drives the count. A full carry chain, up to a century change, settles within a single clock cycle.

Two copies of the time exist. One is the running counter set. The other is a host-facing buffer, and every host access goes through the buffer. A control flag for reads freezes the buffer so the host gets a coherent snapshot. A control flag for writes collects new values in the buffer. Clearing the write flag copies the whole buffer into the counters in one step. Host traffic never stalls the counters.

Top module: `bcd_rtc_ram`

## Requirements
- R1: A bus write (ce_n=0, we_n=0) to an address below 0x1FF8 stores the byte in RAM, indexed by the low RAM_AW address bits. A bus read (ce_n=0, we_n=1, oe_n=0) presents the addressed byte on rdata at the next rising clock edge.
- R2: After reset the registers read as follows: control 0x20, seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00. The address map is 0x1FF8 control, 0x1FF9 seconds, 0x1FFA minutes, 0x1FFB hours, 0x1FFC day, 0x1FFD date, 0x1FFE month, 0x1FFF year.
- R3: Each clock cycle with sec_tick high advances seconds by one in BCD. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours. All of this completes in the same cycle.
- R4: Hours 23 wraps to 00 and advances both the day of week and the date. Day of week counts 1 to 7 and then returns to 1.
- R5: Months 04, 06, 09 and 11 end after date 30. Months 01, 03, 05, 07, 08, 10 and 12 end after date 31. Past the last date, the date returns to 01 and the month advances.
- R6: February ends after date 29 when the BCD year is divisible by four (00 included). It ends after date 28 in all other years.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century.
- R8: While the read flag is set, the time registers read back frozen values and the counters keep running. After the flag clears, the reads show the advanced time.
- R9: While the write flag is set, writes to 0x1FF9–0x1FFF land in the buffer and read back as written, and ticks do not change the buffer. A control write that clears the write flag loads every buffered field, plus the century in that same byte, into the counters at that clock edge.
- R10: A write to 0x1FF9–0x1FFF while the write flag is clear has no effect on the time.
- R11: With ce_n high, no write takes place and rdata keeps its last value.
- R12: The control byte layout is bit 7 write flag, bit 6 read flag, bits 5:0 century in BCD. A control read returns the current flags with the visible century.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable, takes priority over oe_n |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The calendar carry chain runs through a table of start times. Each entry is loaded by the host and then given one tick. The entries separate a plain seconds step, each level of carry, 30-day from 31-day months, leap from non-leap Februaries (the year 00 included), and the year-end case that reaches the century. Directed sequences follow. They show the frozen snapshot against the running counter, buffered writes against ignored writes, and the effect of deselecting the chip. Each is observed only through bus reads.

// File: rtl/bcd_rtc_ram.sv
module bcd_rtc_ram #(
  parameter int ADDR_W = 13,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam logic [7:0] RST_VAL [8] = '{8'h20, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

  // field index: 0 century, 1 sec, 2 min, 3 hour, 4 day, 5 date, 6 month, 7 year
  logic [7:0] ram [RAM_DEPTH];
  logic [7:0] cnt [8];
  logic [7:0] nxt [8];
  logic [7:0] buf_q [8];
  logic       flag_w, flag_r;
  logic       c_min, c_hr, c_day, c_mon, c_yr, c_cen;
  logic       leap;
  logic [7:0] last_date;

  wire       wr     = !ce_n && !we_n;
  wire       rd     = !ce_n && we_n && !oe_n;
  wire       in_win = &addr[ADDR_W-1:3];
  wire [2:0] off    = addr[2:0];
  wire       ctl_wr = wr && in_win && (off == 3'd0);
  wire       load   = ctl_wr && flag_w && !wdata[7];
  wire       track  = !flag_w && !flag_r;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] fld_mask(input logic [2:0] o, input logic [7:0] d);
    case (o)
      3'd1, 3'd2: return d & 8'h7F;
      3'd3, 3'd5: return d & 8'h3F;
      3'd4:       return d & 8'h07;
      3'd6:       return d & 8'h1F;
      3'd0:       return d & 8'h3F;
      default:    return d;
    endcase
  endfunction

  assign leap = cnt[7][4] ? (cnt[7][3:0] == 4'd2 || cnt[7][3:0] == 4'd6)
                          : (cnt[7][3:0] == 4'd0 || cnt[7][3:0] == 4'd4 || cnt[7][3:0] == 4'd8);

  always_comb begin
    case (cnt[6])
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end

  always_comb begin
    nxt = cnt;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0; c_cen = 1'b0;
    if (sec_tick) begin
      if (cnt[1] == 8'h59) begin nxt[1] = 8'h00; c_min = 1'b1; end
      else nxt[1] = bcd_inc(cnt[1]);
    end
    if (c_min) begin
      if (cnt[2] == 8'h59) begin nxt[2] = 8'h00; c_hr = 1'b1; end
      else nxt[2] = bcd_inc(cnt[2]);
    end
    if (c_hr) begin
      if (cnt[3] == 8'h23) begin nxt[3] = 8'h00; c_day = 1'b1; end
      else nxt[3] = bcd_inc(cnt[3]);
    end
    if (c_day) begin
      nxt[4] = (cnt[4] == 8'h07) ? 8'h01 : cnt[4] + 8'h01;
      if (cnt[5] == last_date) begin nxt[5] = 8'h01; c_mon = 1'b1; end
      else nxt[5] = bcd_inc(cnt[5]);
    end
    if (c_mon) begin
      if (cnt[6] == 8'h12) begin nxt[6] = 8'h01; c_yr = 1'b1; end
      else nxt[6] = bcd_inc(cnt[6]);
    end
    if (c_yr) begin
      if (cnt[7] == 8'h99) begin nxt[7] = 8'h00; c_cen = 1'b1; end
      else nxt[7] = bcd_inc(cnt[7]);
    end
    if (c_cen) nxt[0] = (cnt[0] == 8'h39) ? 8'h00 : bcd_inc(cnt[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) cnt[i] <= RST_VAL[i];
    end else if (load) begin
      for (int i = 1; i < 8; i++) cnt[i] <= buf_q[i];
      cnt[0] <= fld_mask(3'd0, wdata);
    end else begin
      cnt <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) buf_q[i] <= RST_VAL[i];
      flag_w <= 1'b0;
      flag_r <= 1'b0;
    end else begin
      if (track) buf_q <= nxt;
      if (ctl_wr) begin
        flag_w <= wdata[7];
        flag_r <= wdata[6];
        if (flag_w || wdata[7]) buf_q[0] <= fld_mask(3'd0, wdata);
      end else if (wr && in_win && flag_w) begin
        buf_q[off] <= fld_mask(off, wdata);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !in_win) ram[addr[RAM_AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'h00;
    else if (rd) begin
      if (!in_win)          rdata <= ram[addr[RAM_AW-1:0]];
      else if (off == 3'd0) rdata <= {flag_w, flag_r, buf_q[0][5:0]};
      else                  rdata <= buf_q[off];
    end
  end

  assert_deselect_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> $stable(rdata));

  assert_idle_sec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !load) |=> $stable(cnt[1]));

  assert_min_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !load && cnt[1] == 8'h59) |=> (cnt[1] == 8'h00 && cnt[2] != $past(cnt[2])));

  assert_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_r && !(wr && in_win)) |=> $stable(buf_q[1]));

  assert_transfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt[1] == $past(buf_q[1]) && cnt[7] == $past(buf_q[7])));

endmodule

// File: tb/bcd_rtc_ram_bench.sv
module bcd_rtc_ram_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int n_run = 0, n_fail = 0;

  bcd_rtc_ram u_bcd_rtc_ram (.clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {century, year, month, date, day, hour, min, sec}
  localparam logic [63:0] VIN [12] = '{
    64'h20_24_03_15_03_10_20_30, 64'h20_24_03_15_03_10_20_59,
    64'h20_24_03_15_03_10_59_59, 64'h20_24_03_15_07_23_59_59,
    64'h20_24_04_30_02_23_59_59, 64'h20_24_05_30_02_23_59_59,
    64'h20_24_02_28_04_23_59_59, 64'h20_23_02_28_04_23_59_59,
    64'h20_00_02_28_01_23_59_59, 64'h20_24_02_29_01_23_59_59,
    64'h20_99_12_31_05_23_59_59, 64'h20_24_11_30_01_23_59_59};
  localparam logic [63:0] VEXP [12] = '{
    64'h20_24_03_15_03_10_20_31, 64'h20_24_03_15_03_10_21_00,
    64'h20_24_03_15_03_11_00_00, 64'h20_24_03_16_01_00_00_00,
    64'h20_24_05_01_03_00_00_00, 64'h20_24_05_31_03_00_00_00,
    64'h20_24_02_29_05_00_00_00, 64'h20_23_03_01_05_00_00_00,
    64'h20_00_02_29_02_00_00_00, 64'h20_24_03_01_02_00_00_00,
    64'h21_00_01_01_06_00_00_00, 64'h20_24_12_01_02_00_00_00};
  localparam int VREQ [12] = '{3, 3, 3, 4, 5, 5, 6, 6, 6, 6, 7, 5};

  function automatic string req_name(input int r);
    case (r)
      3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = a; wdata = d;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic bus_rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = 0; addr = a;
    @(negedge clk); d = rdata; ce_n = 1; oe_n = 1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1;
      @(negedge clk); sec_tick = 0;
    end
  endtask

  task automatic set_time(input logic [63:0] v);
    bus_wr(13'h1FF8, {2'b10, v[61:56]});
    for (int k = 1; k < 8; k++) bus_wr(13'h1FF8 + 13'(k), v[8*(k-1) +: 8]);
    bus_wr(13'h1FF8, {2'b00, v[61:56]});
  endtask

  task automatic chk_time(input string tag, input logic [63:0] v);
    logic [7:0] d;
    bus_rd(13'h1FF8, d); chk(tag, d, {2'b00, v[61:56]});
    for (int k = 1; k < 8; k++) begin
      bus_rd(13'h1FF8 + 13'(k), d); chk(tag, d, v[8*(k-1) +: 8]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    chk_time("R2", 64'h20_00_01_01_01_00_00_00);

    // R3..R7 calendar vector table
    for (int i = 0; i < 12; i++) begin
      set_time(VIN[i]);
      tick(1);
      chk_time(req_name(VREQ[i]), VEXP[i]);
    end

    // R1 RAM access
    bus_wr(13'h0000, 8'h3C); bus_wr(13'h03F7, 8'hC3); bus_wr(13'h0155, 8'hA5);
    bus_rd(13'h0000, d); chk("R1", d, 8'h3C);
    bus_rd(13'h03F7, d); chk("R1", d, 8'hC3);
    bus_rd(13'h0155, d); chk("R1", d, 8'hA5);

    // R11 deselected write has no effect, rdata holds
    @(negedge clk); ce_n = 1; we_n = 0; addr = 13'h0155; wdata = 8'h5A;
    @(negedge clk); we_n = 1; oe_n = 0;
    repeat (2) @(negedge clk);
    chk("R11", rdata, 8'hA5);
    oe_n = 1;
    bus_rd(13'h0155, d); chk("R11", d, 8'hA5);

    // R9 buffered write
    set_time(64'h20_24_03_15_03_10_20_30);
    bus_wr(13'h1FF8, 8'hA0);
    bus_wr(13'h1FF9, 8'h45);
    bus_rd(13'h1FF9, d); chk("R9", d, 8'h45);
    bus_rd(13'h1FF8, d); chk("R12", d, 8'hA0);
    tick(3);
    bus_rd(13'h1FF9, d); chk("R9", d, 8'h45);
    bus_rd(13'h1FFA, d); chk("R9", d, 8'h20);
    bus_wr(13'h1FF8, 8'h20);
    bus_rd(13'h1FF9, d); chk("R9", d, 8'h45);
    bus_rd(13'h1FFA, d); chk("R9", d, 8'h20);

    // R10 write ignored with the write flag clear
    bus_wr(13'h1FF9, 8'h11);
    bus_rd(13'h1FF9, d); chk("R10", d, 8'h45);
    tick(1);
    bus_rd(13'h1FF9, d); chk("R10", d, 8'h46);

    // R8 frozen snapshot while counting continues
    bus_wr(13'h1FF8, 8'h60);
    bus_rd(13'h1FF8, d); chk("R12", d, 8'h60);
    bus_rd(13'h1FF9, d); chk("R8", d, 8'h46);
    tick(2);
    bus_rd(13'h1FF9, d); chk("R8", d, 8'h46);
    bus_wr(13'h1FF8, 8'h20);
    bus_rd(13'h1FF9, d); chk("R8", d, 8'h48);
    bus_rd(13'h1FF8, d); chk("R12", d, 8'h20);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule